// File: doc/BRIEF.md
# Switch address table command engine

This block keeps a small forwarding table for an Ethernet switch. Each table slot holds a 48-bit station address, a database number, a 4-bit entry state, a trunk flag and a port vector. Software never reaches the slots directly. It stages operands in a handful of 16-bit registers, then writes a command word with the busy bit set. The engine walks the whole table, one slot per clock, and finishes in a final cycle that commits a result. Busy then drops.

There are three command families. Load/purge installs or removes one address. Get-next steps through one database in ascending address order, handing back one entry per command. Flush/move acts on every entry that matches a scope chosen by the opcode. The data register decides whether it deletes those entries or rewrites their port vectors. The database number is selected by a parameter. For tables of at most 256 databases it is assembled from a nibble in the command word and a nibble in the control word. Larger tables use a dedicated 12-bit register.

Top module: `fdb_cmd_engine`

## Requirements
- R1: A write to register 0 with bit 15 set, while idle, starts a command. Bit 15 of register 0 reads 1 from the next cycle on and returns to 0 no more than DEPTH+1 cycles after it rose. Register 0 holds the opcode in bits 14:12 and the low database nibble in bits 3:0.
- R2: While busy is set, every bus write is ignored, including a second command word. This holds for the control word, the address registers and register 0.
- R3: Register 1 holds the entry state in bits 3:0, the port vector from bit 4 upward (PV_W bits), and the trunk flag in bit 15. The other bits read 0.
- R4: The station address occupies registers 2, 3 and 4. Byte 0 (the first octet) sits in register 2 bits 15:8, byte 1 in register 2 bits 7:0, and so on through byte 5 in register 4 bits 7:0.
- R5: With NUM_DB at most 256, the selected database is {control bits 15:12, register 0 bits 3:0}. Two databases that differ only in the high nibble are kept apart.
- R6: Opcode 1 with a nonzero state writes the address, state, trunk flag and port vector into the selected database. It overwrites an existing entry with the same address and database, or fills a free slot otherwise. Opcode 1 with state 0 removes that entry.
- R7: Opcode 2 returns, in registers 1 to 4, the valid entry of the selected database with the smallest address above the address held in registers 2 to 4. An all-ones start address begins from the lowest entry. Entries of other databases are skipped.
- R8: When opcode 2 finds no further entry, register 1 reads 0 and registers 2 to 4 read 0xFFFF.
- R9: With state 0 in register 1, opcodes 4 to 7 delete matching valid entries. Opcode bit 0 limits the scope to the selected database, and opcode bit 1 spares static entries (states 0xE and 0xF).
- R10: With state 0xF in register 1, opcodes 4 to 7 perform a move. Port-vector bits 3:0 give a source port number and bits 7:4 give a destination port number. Every in-scope entry whose vector holds the source port has that bit cleared and the destination bit set. Its state is unchanged, and entries without the source port stay as they were.
- R11: A move whose destination number is 0xF only clears the source port bit.
- R12: Register 6 holds the age time in bits 11:4 and the learn-to-all enable in bit 3. Its bits 2:0 read 0, and each field reads back what was written.
- R13: After reset all registers read 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select: 0 command, 1 data, 2-4 address, 5 database ID, 6 control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |

## Verification
A wrong slot in the table stays invisible at the ports until a later get-next walks over it. A corrupted entry therefore surfaces one command later, in the data or address registers, roughly DEPTH+2 cycles after the faulty command. The command sequence reads every surviving entry back after each load, purge, flush and move. A scan that stops early or never ends shows up at once in register 0 bit 15. A lost or mis-merged database nibble returns an entry from the wrong database at the next step of an iteration.

// File: rtl/fdb_pkg.sv
package fdb_pkg;
    localparam int MAC_W = 48;
    localparam int ST_W  = 4;

    localparam logic [ST_W-1:0] ST_FREE = 4'h0;
    localparam logic [ST_W-1:0] ST_ALL1 = 4'hF;
    localparam logic [ST_W-1:0] ST_PIN  = 4'hE;

    localparam logic [2:0] A_OP   = 3'd0;
    localparam logic [2:0] A_DATA = 3'd1;
    localparam logic [2:0] A_MAC0 = 3'd2;
    localparam logic [2:0] A_MAC1 = 3'd3;
    localparam logic [2:0] A_MAC2 = 3'd4;
    localparam logic [2:0] A_DBID = 3'd5;
    localparam logic [2:0] A_CTRL = 3'd6;

    typedef enum logic [2:0] {
        OPC_NONE       = 3'd0,
        OPC_LOAD       = 3'd1,
        OPC_NEXT       = 3'd2,
        OPC_UNUSED     = 3'd3,
        OPC_FL_ALL     = 3'd4,
        OPC_FL_ALL_SEL = 3'd5,
        OPC_FL_DYN     = 3'd6,
        OPC_FL_DYN_SEL = 3'd7
    } fdb_opc_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_END  = 2'd2
    } fdb_phase_e;
endpackage

// File: rtl/fdb_table.sv
module fdb_table
    import fdb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int DB_W  = 8,
    parameter int PV_W  = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [MAC_W-1:0] rd_mac,
    output logic [DB_W-1:0]  rd_db,
    output logic [ST_W-1:0]  rd_st,
    output logic             rd_tr,
    output logic [PV_W-1:0]  rd_pv,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [MAC_W-1:0] wr_mac,
    input  logic [DB_W-1:0]  wr_db,
    input  logic [ST_W-1:0]  wr_st,
    input  logic             wr_tr,
    input  logic [PV_W-1:0]  wr_pv
);
    logic [MAC_W-1:0] mac_q [DEPTH];
    logic [DB_W-1:0]  db_q  [DEPTH];
    logic [ST_W-1:0]  st_q  [DEPTH];
    logic             tr_q  [DEPTH];
    logic [PV_W-1:0]  pv_q  [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mac_q[i] <= '0;
                db_q[i]  <= '0;
                st_q[i]  <= ST_FREE;
                tr_q[i]  <= 1'b0;
                pv_q[i]  <= '0;
            end
        end else if (we) begin
            mac_q[wr_idx] <= wr_mac;
            db_q[wr_idx]  <= wr_db;
            st_q[wr_idx]  <= wr_st;
            tr_q[wr_idx]  <= wr_tr;
            pv_q[wr_idx]  <= wr_pv;
        end
    end

    assign rd_mac = mac_q[rd_idx];
    assign rd_db  = db_q[rd_idx];
    assign rd_st  = st_q[rd_idx];
    assign rd_tr  = tr_q[rd_idx];
    assign rd_pv  = pv_q[rd_idx];
endmodule

// File: rtl/fdb_rewrite.sv
module fdb_rewrite
    import fdb_pkg::*;
#(
    parameter int DB_W = 8,
    parameter int PV_W = 8
)(
    input  logic [ST_W-1:0] ent_st,
    input  logic [PV_W-1:0] ent_pv,
    input  logic [DB_W-1:0] ent_db,
    input  logic [DB_W-1:0] sel_db,
    input  logic            db_only,
    input  logic            dyn_only,
    input  logic [ST_W-1:0] act_st,
    input  logic [PV_W-1:0] act_pv,
    output logic            hit,
    output logic [ST_W-1:0] new_st,
    output logic [PV_W-1:0] new_pv
);
    localparam int SEL_W = $clog2(PV_W) + 1;

    logic [SEL_W-1:0] src, dst;
    logic [PV_W-1:0]  src_bit, dst_bit;
    logic             in_scope;

    assign src      = act_pv[SEL_W-1:0];
    assign dst      = act_pv[2*SEL_W-1:SEL_W];
    assign src_bit  = PV_W'(1) << src;
    assign dst_bit  = (&dst) ? '0 : (PV_W'(1) << dst);
    assign in_scope = (ent_st != ST_FREE)
                    && (!db_only || ent_db == sel_db)
                    && (!dyn_only || ent_st < ST_PIN);

    always_comb begin
        hit    = 1'b0;
        new_st = ent_st;
        new_pv = ent_pv;
        if (act_st == ST_FREE) begin
            hit    = in_scope;
            new_st = ST_FREE;
            new_pv = '0;
        end else if (act_st == ST_ALL1) begin
            hit    = in_scope && ((ent_pv & src_bit) != '0);
            new_pv = (ent_pv & ~src_bit) | dst_bit;
        end
    end
endmodule

// File: rtl/fdb_next_pick.sv
module fdb_next_pick
    import fdb_pkg::*;
#(
    parameter int DB_W = 8
)(
    input  logic [ST_W-1:0]  cand_st,
    input  logic [DB_W-1:0]  cand_db,
    input  logic [MAC_W-1:0] cand_mac,
    input  logic [DB_W-1:0]  sel_db,
    input  logic [MAC_W-1:0] start_mac,
    input  logic             best_v,
    input  logic [MAC_W-1:0] best_mac,
    output logic             better
);
    logic above;

    assign above  = (&start_mac) || (cand_mac > start_mac);
    assign better = (cand_st != ST_FREE) && (cand_db == sel_db) && above
                  && (!best_v || cand_mac < best_mac);
endmodule

// File: rtl/fdb_cmd_engine.sv
module fdb_cmd_engine
    import fdb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NUM_DB = 256,
    parameter int PV_W   = 8
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int DB_W  = (NUM_DB > 1) ? $clog2(NUM_DB) : 1;

    typedef struct packed {
        fdb_phase_e       ph;
        logic [IDX_W-1:0] idx;
        logic             busy;
        fdb_opc_e         opc;
        logic [3:0]       dblo;
        logic [ST_W-1:0]  d_st;
        logic             d_tr;
        logic [PV_W-1:0]  d_pv;
        logic [MAC_W-1:0] mac;
        logic [11:0]      dbid;
        logic [3:0]       dbhi;
        logic [7:0]       age;
        logic             learn;
        logic             hit_v;
        logic [IDX_W-1:0] hit_idx;
        logic [MAC_W-1:0] best_mac;
        logic             free_v;
        logic [IDX_W-1:0] free_idx;
    } regs_t;

    regs_t r_q, r_d;

    logic [IDX_W-1:0] rd_idx, w_idx;
    logic [MAC_W-1:0] t_mac, w_mac;
    logic [DB_W-1:0]  t_db, w_db, sel_db;
    logic [ST_W-1:0]  t_st, w_st, rw_st;
    logic             t_tr, w_tr, tbl_we, rw_hit, better;
    logic [PV_W-1:0]  t_pv, w_pv, rw_pv;

    logic             busy_w;
    logic [2:0]       opc_w;
    logic [ST_W-1:0]  dst_w;
    logic [MAC_W-1:0] mac_w;
    logic [15:0]      ctrl_w;

    generate
        if (NUM_DB > 256) begin : g_wide_db
            assign sel_db = r_q.dbid[DB_W-1:0];
        end else begin : g_split_db
            logic [7:0] joined;
            assign joined = {r_q.dbhi, r_q.dblo};
            assign sel_db = joined[DB_W-1:0];
        end
    endgenerate

    assign rd_idx = (r_q.ph == PH_END) ? r_q.hit_idx : r_q.idx;

    fdb_table #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DB_W(DB_W), .PV_W(PV_W)) u_table (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx),
        .rd_mac(t_mac), .rd_db(t_db), .rd_st(t_st), .rd_tr(t_tr), .rd_pv(t_pv),
        .we(tbl_we), .wr_idx(w_idx),
        .wr_mac(w_mac), .wr_db(w_db), .wr_st(w_st), .wr_tr(w_tr), .wr_pv(w_pv)
    );

    fdb_rewrite #(.DB_W(DB_W), .PV_W(PV_W)) u_rewrite (
        .ent_st(t_st), .ent_pv(t_pv), .ent_db(t_db), .sel_db(sel_db),
        .db_only(r_q.opc[0]), .dyn_only(r_q.opc[1]),
        .act_st(r_q.d_st), .act_pv(r_q.d_pv),
        .hit(rw_hit), .new_st(rw_st), .new_pv(rw_pv)
    );

    fdb_next_pick #(.DB_W(DB_W)) u_pick (
        .cand_st(t_st), .cand_db(t_db), .cand_mac(t_mac), .sel_db(sel_db),
        .start_mac(r_q.mac), .best_v(r_q.hit_v), .best_mac(r_q.best_mac),
        .better(better)
    );

    always_comb begin
        r_d    = r_q;
        tbl_we = 1'b0;
        w_idx  = r_q.idx;
        w_mac  = t_mac;
        w_db   = t_db;
        w_st   = t_st;
        w_tr   = t_tr;
        w_pv   = t_pv;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (bus_we) begin
                    case (bus_addr)
                        A_OP: begin
                            r_d.opc  = fdb_opc_e'(bus_wdata[14:12]);
                            r_d.dblo = bus_wdata[3:0];
                            if (bus_wdata[15]) begin
                                r_d.busy   = 1'b1;
                                r_d.ph     = PH_SCAN;
                                r_d.idx    = '0;
                                r_d.hit_v  = 1'b0;
                                r_d.free_v = 1'b0;
                            end
                        end
                        A_DATA: begin
                            r_d.d_st = bus_wdata[3:0];
                            r_d.d_pv = bus_wdata[4 +: PV_W];
                            r_d.d_tr = bus_wdata[15];
                        end
                        A_MAC0: r_d.mac[47:32] = bus_wdata;
                        A_MAC1: r_d.mac[31:16] = bus_wdata;
                        A_MAC2: r_d.mac[15:0]  = bus_wdata;
                        A_DBID: r_d.dbid       = bus_wdata[11:0];
                        A_CTRL: begin
                            r_d.dbhi  = bus_wdata[15:12];
                            r_d.age   = bus_wdata[11:4];
                            r_d.learn = bus_wdata[3];
                        end
                        default: ;
                    endcase
                end
            end
            PH_SCAN: begin
                if (r_q.opc == OPC_LOAD) begin
                    if (t_st != ST_FREE && t_db == sel_db && t_mac == r_q.mac) begin
                        r_d.hit_v   = 1'b1;
                        r_d.hit_idx = r_q.idx;
                    end
                    if (t_st == ST_FREE && !r_q.free_v) begin
                        r_d.free_v   = 1'b1;
                        r_d.free_idx = r_q.idx;
                    end
                end else if (r_q.opc == OPC_NEXT) begin
                    if (better) begin
                        r_d.hit_v    = 1'b1;
                        r_d.hit_idx  = r_q.idx;
                        r_d.best_mac = t_mac;
                    end
                end else if (r_q.opc[2] && rw_hit) begin
                    tbl_we = 1'b1;
                    w_st   = rw_st;
                    w_pv   = rw_pv;
                end
                if (r_q.idx == IDX_W'(DEPTH - 1)) r_d.ph = PH_END;
                else r_d.idx = r_q.idx + IDX_W'(1);
            end
            PH_END: begin
                if (r_q.opc == OPC_LOAD) begin
                    if (r_q.d_st != ST_FREE && (r_q.hit_v || r_q.free_v)) begin
                        tbl_we = 1'b1;
                        w_idx  = r_q.hit_v ? r_q.hit_idx : r_q.free_idx;
                        w_mac  = r_q.mac;
                        w_db   = sel_db;
                        w_st   = r_q.d_st;
                        w_tr   = r_q.d_tr;
                        w_pv   = r_q.d_pv;
                    end else if (r_q.d_st == ST_FREE && r_q.hit_v) begin
                        tbl_we = 1'b1;
                        w_idx  = r_q.hit_idx;
                        w_st   = ST_FREE;
                        w_tr   = 1'b0;
                        w_pv   = '0;
                    end
                end else if (r_q.opc == OPC_NEXT) begin
                    if (r_q.hit_v) begin
                        r_d.mac  = t_mac;
                        r_d.d_st = t_st;
                        r_d.d_tr = t_tr;
                        r_d.d_pv = t_pv;
                    end else begin
                        r_d.mac  = '1;
                        r_d.d_st = ST_FREE;
                        r_d.d_tr = 1'b0;
                        r_d.d_pv = '0;
                    end
                end
                r_d.busy = 1'b0;
                r_d.ph   = PH_IDLE;
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_w = r_q.busy;
    assign opc_w  = r_q.opc;
    assign dst_w  = r_q.d_st;
    assign mac_w  = r_q.mac;
    assign ctrl_w = {r_q.dbhi, r_q.age, r_q.learn, 3'b000};

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_OP:   bus_rdata = {r_q.busy, opc_w, 8'h00, r_q.dblo};
            A_DATA: begin
                bus_rdata[3:0]        = r_q.d_st;
                bus_rdata[4 +: PV_W]  = r_q.d_pv;
                bus_rdata[15]         = r_q.d_tr;
            end
            A_MAC0: bus_rdata = mac_w[47:32];
            A_MAC1: bus_rdata = mac_w[31:16];
            A_MAC2: bus_rdata = mac_w[15:0];
            A_DBID: bus_rdata = {4'h0, r_q.dbid};
            A_CTRL: bus_rdata = ctrl_w;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fdb_cmd_engine_chk.sv
module fdb_cmd_engine_chk
    import fdb_pkg::*;
#(
    parameter int DEPTH = 16
)(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        busy,
    input logic [2:0]  opc,
    input logic [3:0]  d_st,
    input logic [47:0] mac,
    input logic [15:0] ctrl,
    input logic        tbl_we
);
    int busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    // R1: a command word with bit 15 raises busy on the next cycle
    p_busy_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_we && bus_addr == A_OP && bus_wdata[15]) |=> busy);

    // R1: a command ends within DEPTH+1 busy cycles
    p_busy_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt <= DEPTH));

    // R1: the table changes only while a command runs
    p_quiet_table_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tbl_we);

    // R2: writes during a command leave the control word alone
    p_frozen_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we) |=> $stable(ctrl));

    // R8: an exhausted get-next leaves the all-ones address marker
    p_end_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && opc == 3'd2 && d_st == 4'h0) |-> (&mac));
endmodule

bind fdb_cmd_engine fdb_cmd_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy_w), .opc(opc_w), .d_st(dst_w),
    .mac(mac_w), .ctrl(ctrl_w), .tbl_we(tbl_we)
);

// File: tb/fdb_cmd_engine_test.sv
module fdb_cmd_engine_test;
    import fdb_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;

    int    n_run = 0;
    int    n_fail = 0;
    item_t sb_q[$];
    logic [7:0] age_m = 8'h00;
    logic       learn_m = 1'b0;

    fdb_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // monitor: compares queued expectations one step after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_run++;
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        sb_q.push_back('{exp: e, tag: tag});
        #2;
    endtask

    task automatic wait_idle();
        bit done = 1'b0;
        for (int i = 0; i < 200 && !done; i++) begin
            @(negedge clk);
            bus_addr = A_OP;
            #1;
            if (!bus_rdata[15]) done = 1'b1;
        end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R1 busy stuck: actual 1 expected 0");
        end
    endtask

    task automatic run_cmd(input logic [2:0] opc, input logic [7:0] db);
        wr(A_CTRL, {db[7:4], age_m, learn_m, 3'b000});
        wr(A_OP, {1'b1, opc, 8'h00, db[3:0]});
        rd_chk(A_OP, {1'b1, opc, 8'h00, db[3:0]}, "R1 busy set");
        wait_idle();
        rd_chk(A_OP, {1'b0, opc, 8'h00, db[3:0]}, "R1 busy cleared");
    endtask

    task automatic set_mac(input logic [15:0] m0, input logic [15:0] m1, input logic [15:0] m2);
        wr(A_MAC0, m0); wr(A_MAC1, m1); wr(A_MAC2, m2);
    endtask

    task automatic load(input logic [7:0] db, input logic [15:0] m0, input logic [15:0] m1,
                        input logic [15:0] m2, input logic [15:0] data);
        set_mac(m0, m1, m2);
        wr(A_DATA, data);
        run_cmd(3'd1, db);
    endtask

    task automatic result_chk(input logic [15:0] ed, input logic [15:0] e0, input logic [15:0] e1,
                              input logic [15:0] e2, input string tag);
        rd_chk(A_DATA, ed, tag);
        rd_chk(A_MAC0, e0, tag);
        rd_chk(A_MAC1, e1, tag);
        rd_chk(A_MAC2, e2, tag);
    endtask

    task automatic gn_chk(input logic [7:0] db, input logic [15:0] ed, input logic [15:0] e0,
                          input logic [15:0] e1, input logic [15:0] e2, input string tag);
        run_cmd(3'd2, db);
        result_chk(ed, e0, e1, e2, tag);
    endtask

    task automatic gn_start(input logic [7:0] db, input logic [15:0] ed, input logic [15:0] e0,
                            input logic [15:0] e1, input logic [15:0] e2, input string tag);
        set_mac(16'hFFFF, 16'hFFFF, 16'hFFFF);
        gn_chk(db, ed, e0, e1, e2, tag);
    endtask

    task automatic gn_end(input logic [7:0] db, input string tag);
        gn_chk(db, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, tag);
    endtask

    task automatic flushmove(input logic [2:0] opc, input logic [7:0] db, input logic [15:0] data);
        wr(A_DATA, data);
        run_cmd(opc, db);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R13: reset values
        rd_chk(A_OP,   16'h0000, "R13 command reg");
        rd_chk(A_DATA, 16'h0000, "R13 data reg");
        rd_chk(A_MAC0, 16'h0000, "R13 address reg");
        rd_chk(A_CTRL, 16'h0000, "R13 control reg");
        gn_start(8'h00, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R13 empty table");

        // R12: control fields
        wr(A_CTRL, 16'h05AF);
        rd_chk(A_CTRL, 16'h05A8, "R12 age and learn fields");
        age_m = 8'h5A; learn_m = 1'b1;

        // R6, R3: install four entries
        load(8'h12, 16'h0011, 16'h2233, 16'h4455, 16'h0037);
        load(8'h12, 16'h0011, 16'h2233, 16'h4410, 16'h002E);
        load(8'h12, 16'hAABB, 16'hCCDD, 16'hEE01, 16'h8045);
        load(8'h03, 16'h0000, 16'h0000, 16'h0001, 16'h0027);

        // R2: writes ignored while a get-next runs
        set_mac(16'hFFFF, 16'hFFFF, 16'hFFFF);
        wr(A_CTRL, 16'h15A8);
        wr(A_OP, 16'hA002);
        wr(A_CTRL, 16'hFFFF);
        wr(A_MAC0, 16'h1234);
        wr(A_OP, 16'hC002);
        wait_idle();
        rd_chk(A_CTRL, 16'h15A8, "R2 control unchanged");
        rd_chk(A_OP, 16'h2002, "R2 command unchanged");
        result_chk(16'h002E, 16'h0011, 16'h2233, 16'h4410, "R2 R4 R7 first entry");

        // R7, R3, R8: continue the iteration
        gn_chk(8'h12, 16'h0037, 16'h0011, 16'h2233, 16'h4455, "R7 second entry");
        gn_chk(8'h12, 16'h8045, 16'hAABB, 16'hCCDD, 16'hEE01, "R3 R7 trunk entry");
        gn_end(8'h12, "R8 end marker");

        // R5: database split
        gn_start(8'h02, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R5 high nibble separates");
        gn_start(8'h03, 16'h0027, 16'h0000, 16'h0000, 16'h0001, "R5 low database");

        // R6: purge and update
        load(8'h12, 16'hAABB, 16'hCCDD, 16'hEE01, 16'h0000);
        set_mac(16'h0011, 16'h2233, 16'h4455);
        gn_end(8'h12, "R6 purged entry gone");
        load(8'h12, 16'h0011, 16'h2233, 16'h4455, 16'h0097);
        set_mac(16'h0011, 16'h2233, 16'h4410);
        gn_chk(8'h12, 16'h0097, 16'h0011, 16'h2233, 16'h4455, "R6 updated entry");

        // R9: flush non-static in selected database
        flushmove(3'd7, 8'h12, 16'h0000);
        gn_start(8'h12, 16'h002E, 16'h0011, 16'h2233, 16'h4410, "R9 static kept");
        gn_end(8'h12, "R9 dynamic flushed");
        gn_start(8'h03, 16'h0027, 16'h0000, 16'h0000, 16'h0001, "R9 other database kept");

        // R10: move port 3 to port 1 in database 0x12
        load(8'h12, 16'h0011, 16'h2233, 16'h4455, 16'h0097);
        flushmove(3'd5, 8'h12, 16'h013F);
        gn_start(8'h12, 16'h002E, 16'h0011, 16'h2233, 16'h4410, "R10 no source port untouched");
        gn_chk(8'h12, 16'h0037, 16'h0011, 16'h2233, 16'h4455, "R10 moved entry");

        // R11: remove port 1 everywhere
        flushmove(3'd4, 8'h12, 16'h0F1F);
        gn_start(8'h12, 16'h000E, 16'h0011, 16'h2233, 16'h4410, "R11 static port removed");
        gn_chk(8'h12, 16'h0017, 16'h0011, 16'h2233, 16'h4455, "R11 port removed");
        gn_start(8'h03, 16'h0007, 16'h0000, 16'h0000, 16'h0001, "R11 all databases");

        // R9: non-static flush across databases, then full flush
        flushmove(3'd6, 8'h12, 16'h0000);
        gn_start(8'h03, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R9 all-database dynamic flush");
        gn_start(8'h12, 16'h000E, 16'h0011, 16'h2233, 16'h4410, "R9 static survives");
        flushmove(3'd4, 8'h12, 16'h0000);
        gn_start(8'h12, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R9 full flush");

        @(negedge clk);
        #3;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule